// File: doc/BRIEF.md
# Vector byte-extract execute unit

This unit decodes one SIMD byte-extract instruction and executes it against a local file of 32 registers, each 64 bits wide. A 32-bit instruction word arrives with a valid strobe. The unit checks the encoding and the operand legality. A legal instruction writes a contiguous byte window, taken from two or three concatenated source registers, into one destination register (64-bit form) or into an even/odd destination pair (128-bit form).

An instruction that fails any check raises a one-cycle undefined flag and leaves the register file untouched. A side port writes and reads registers directly, so a test environment can preload operands and inspect results. The configuration input `hi_bank_en_i` states whether registers 16 to 31 exist.

Top module: `vext_unit`

## Requirements
- R1: An instruction is accepted only when bits[31:23] = 9'b1111_0010_1, bits[21:20] = 2'b11 and bit[4] = 0. Any other word presented with `insn_valid_i` raises `undef_o` and writes nothing. Fields: destination vd = {insn[22], insn[15:12]}, first source vn = {insn[7], insn[19:16]}, second source vm = {insn[5], insn[3:0]}, byte offset imm = insn[11:8], width select q = insn[6].
- R2: With q=0 and imm at most 7, register vd receives bytes imm to imm+7 of the 128-bit value {R[vm], R[vn]}. Byte order is little-endian: byte 0 is bits [7:0] of R[vn].
- R3: With q=0 and imm greater than 7, the instruction is undefined.
- R4: With q=1, an odd vd, vn or vm makes the instruction undefined.
- R5: With q=1 and imm below 8, R[vd] receives the window at byte imm of {R[vn+1], R[vn]}, and R[vd+1] receives the window at byte imm of {R[vm], R[vn+1]}.
- R6: With q=1 and imm 8 or more, R[vd] receives the window at byte imm-8 of {R[vm], R[vn+1]}, and R[vd+1] receives the window at byte imm-8 of {R[vm+1], R[vm]}.
- R7: When `hi_bank_en_i` is 0, any of vd, vn or vm with bit 4 set makes the instruction undefined.
- R8: An offset of 0 or 8 yields an exact copy of a whole source register.
- R9: All sources are read before any destination is written, so overlapping source and destination registers give the atomic result.
- R10: `done_o` (legal) or `undef_o` (illegal) is high for exactly the one cycle after the edge that samples a valid instruction, and never both. An undefined instruction leaves every register unchanged.
- R11: After reset, `done_o` and `undef_o` are low and every register reads zero.
- R12: A side-port write stores `dbg_wdata_i` at `dbg_waddr_i` on the clock edge. `dbg_rdata_o` shows register `dbg_raddr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word |
| hi_bank_en_i | input | 1 | 1: registers 16-31 exist |
| dbg_we_i | input | 1 | Side-port write enable |
| dbg_waddr_i | input | 5 | Side-port write address |
| dbg_wdata_i | input | 64 | Side-port write data |
| dbg_raddr_i | input | 5 | Side-port read address |
| dbg_rdata_o | output | 64 | Side-port read data |
| done_o | output | 1 | Legal instruction executed |
| undef_o | output | 1 | Instruction undefined |

## Verification
A wrong pair selection or shift in the funnel shows on the first read of the destination after the instruction, one edge after the strobe. Each offset lane and each half of the pair therefore gets its own vector. A legality fault appears in the same cycle at the flags. It also appears as a changed register, which the bench catches by reading the would-be destination back after every rejected word. A premature write in an overlapping case shows up as a result mixed from old and new data.

// File: rtl/vext_pkg.sv
package vext_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_REGS = 32;
  localparam int unsigned REG_AW   = $clog2(NUM_REGS);
  localparam int unsigned IMM_W    = 4;
  localparam int unsigned SH_W     = IMM_W - 1;

  typedef struct packed {
    logic [REG_AW-1:0] vd;
    logic [REG_AW-1:0] vn;
    logic [REG_AW-1:0] vm;
    logic [IMM_W-1:0]  imm;
    logic              q;
  } vext_op_t;
endpackage

// File: rtl/vext_decode.sv
module vext_decode
  import vext_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] insn_i,
  input  logic        hi_bank_en_i,
  output vext_op_t    op_o,
  output logic        exec_o,
  output logic        undef_o
);
  logic match, odd_bad, imm_bad, bank_bad;

  assign match = (insn_i[31:23] == 9'b1111_0010_1) && (insn_i[21:20] == 2'b11) && !insn_i[4];

  assign op_o.vd  = {insn_i[22], insn_i[15:12]};
  assign op_o.vn  = {insn_i[7],  insn_i[19:16]};
  assign op_o.vm  = {insn_i[5],  insn_i[3:0]};
  assign op_o.imm = insn_i[11:8];
  assign op_o.q   = insn_i[6];

  assign odd_bad  = op_o.q && (op_o.vd[0] || op_o.vn[0] || op_o.vm[0]);
  assign imm_bad  = !op_o.q && op_o.imm[IMM_W-1];
  assign bank_bad = !hi_bank_en_i &&
                    (op_o.vd[REG_AW-1] || op_o.vn[REG_AW-1] || op_o.vm[REG_AW-1]);

  assign exec_o  = valid_i && match && !odd_bad && !imm_bad && !bank_bad;
  assign undef_o = valid_i && !exec_o;
endmodule

// File: rtl/vext_funnel.sv
module vext_funnel
  import vext_pkg::*;
(
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [SH_W-1:0]   sh_i,
  output logic [DATA_W-1:0] win_o
);
  localparam int unsigned NBYTES = DATA_W / BYTE_W;
  logic [2*DATA_W-1:0] cat;
  assign cat = {hi_i, lo_i};

  for (genvar j = 0; j < NBYTES; j++) begin : g_byte
    logic [$clog2(2*NBYTES)-1:0] idx;
    assign idx = $clog2(2*NBYTES)'(sh_i) + $clog2(2*NBYTES)'(j);
    assign win_o[j*BYTE_W +: BYTE_W] = cat[idx*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/vext_regfile.sv
module vext_regfile
  import vext_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] ra_i [4],
  output logic [DATA_W-1:0] rd_o [4],
  input  logic              we_lo_i,
  input  logic [REG_AW-1:0] wa_lo_i,
  input  logic [DATA_W-1:0] wd_lo_i,
  input  logic              we_hi_i,
  input  logic [REG_AW-1:0] wa_hi_i,
  input  logic [DATA_W-1:0] wd_hi_i,
  input  logic              dbg_we_i,
  input  logic [REG_AW-1:0] dbg_waddr_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  input  logic [REG_AW-1:0] dbg_raddr_i,
  output logic [DATA_W-1:0] dbg_rdata_o
);
  logic [DATA_W-1:0] rf_q [NUM_REGS];

  for (genvar p = 0; p < 4; p++) begin : g_rd
    assign rd_o[p] = rf_q[ra_i[p]];
  end
  assign dbg_rdata_o = rf_q[dbg_raddr_i];

  // instruction writes override the side port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) rf_q[i] <= '0;
    end else begin
      if (dbg_we_i) rf_q[dbg_waddr_i] <= dbg_wdata_i;
      if (we_lo_i)  rf_q[wa_lo_i]     <= wd_lo_i;
      if (we_hi_i)  rf_q[wa_hi_i]     <= wd_hi_i;
    end
  end
endmodule

// File: rtl/vext_unit.sv
module vext_unit
  import vext_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_valid_i,
  input  logic [31:0]       insn_i,
  input  logic              hi_bank_en_i,
  input  logic              dbg_we_i,
  input  logic [REG_AW-1:0] dbg_waddr_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  input  logic [REG_AW-1:0] dbg_raddr_i,
  output logic [DATA_W-1:0] dbg_rdata_o,
  output logic              done_o,
  output logic              undef_o
);
  vext_op_t op;
  logic exec, undef_d;
  logic [REG_AW-1:0] ra [4];
  logic [DATA_W-1:0] rd [4];
  logic [DATA_W-1:0] lo_lo, lo_hi, hi_lo, hi_hi, win_lo, win_hi;
  logic done_q, undef_q;

  vext_decode u_dec (
    .valid_i(insn_valid_i), .insn_i(insn_i), .hi_bank_en_i(hi_bank_en_i),
    .op_o(op), .exec_o(exec), .undef_o(undef_d)
  );

  // ports: Rn, Rn|1, Rm, Rm|1
  assign ra[0] = op.vn;
  assign ra[1] = {op.vn[REG_AW-1:1], 1'b1};
  assign ra[2] = op.vm;
  assign ra[3] = {op.vm[REG_AW-1:1], 1'b1};

  always_comb begin
    if (!op.q) begin
      lo_lo = rd[0]; lo_hi = rd[2];
      hi_lo = rd[2]; hi_hi = rd[3];
    end else if (!op.imm[IMM_W-1]) begin
      lo_lo = rd[0]; lo_hi = rd[1];
      hi_lo = rd[1]; hi_hi = rd[2];
    end else begin
      lo_lo = rd[1]; lo_hi = rd[2];
      hi_lo = rd[2]; hi_hi = rd[3];
    end
  end

  vext_funnel u_fun_lo (.lo_i(lo_lo), .hi_i(lo_hi), .sh_i(op.imm[SH_W-1:0]), .win_o(win_lo));
  vext_funnel u_fun_hi (.lo_i(hi_lo), .hi_i(hi_hi), .sh_i(op.imm[SH_W-1:0]), .win_o(win_hi));

  vext_regfile u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ra_i(ra), .rd_o(rd),
    .we_lo_i(exec), .wa_lo_i(op.vd), .wd_lo_i(win_lo),
    .we_hi_i(exec && op.q), .wa_hi_i({op.vd[REG_AW-1:1], 1'b1}), .wd_hi_i(win_hi),
    .dbg_we_i(dbg_we_i), .dbg_waddr_i(dbg_waddr_i), .dbg_wdata_i(dbg_wdata_i),
    .dbg_raddr_i(dbg_raddr_i), .dbg_rdata_o(dbg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      done_q  <= exec;
      undef_q <= undef_d;
    end
  end

  assign done_o  = done_q;
  assign undef_o = undef_q;
endmodule

// File: rtl/vext_unit_chk.sv
module vext_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        insn_valid_i,
  input logic [31:0] insn_i,
  input logic        hi_bank_en_i,
  input logic        done_o,
  input logic        undef_o
);
  logic match, q, hi_reg, odd_reg;
  assign match   = (insn_i[31:23] == 9'b1111_0010_1) && (insn_i[21:20] == 2'b11) && !insn_i[4];
  assign q       = insn_i[6];
  assign hi_reg  = insn_i[22] || insn_i[7] || insn_i[5];
  assign odd_reg = insn_i[12] || insn_i[16] || insn_i[0];

  p_flags_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && undef_o));
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_valid_i |=> (!done_o && !undef_o));
  p_flag_resp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_i |=> (done_o || undef_o));
  p_nomatch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_i && !match) |=> undef_o);
  p_imm_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_i && !q && insn_i[11]) |=> undef_o);
  p_odd_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_i && q && odd_reg) |=> undef_o);
  p_bank_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_valid_i && !hi_bank_en_i && hi_reg) |=> undef_o);
endmodule

bind vext_unit vext_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .insn_valid_i(insn_valid_i), .insn_i(insn_i),
  .hi_bank_en_i(hi_bank_en_i), .done_o(done_o), .undef_o(undef_o)
);

// File: tb/vext_unit_bench.sv
module vext_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic        hi_bank_en = 1'b1;
  logic        dbg_we = 1'b0;
  logic [4:0]  dbg_waddr = '0;
  logic [63:0] dbg_wdata = '0;
  logic [4:0]  dbg_raddr = '0;
  logic [63:0] dbg_rdata;
  logic        done, undef;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vext_unit u_vext_unit (
    .clk_i(clk), .rst_ni(rst_n), .insn_valid_i(insn_valid), .insn_i(insn),
    .hi_bank_en_i(hi_bank_en), .dbg_we_i(dbg_we), .dbg_waddr_i(dbg_waddr),
    .dbg_wdata_i(dbg_wdata), .dbg_raddr_i(dbg_raddr), .dbg_rdata_o(dbg_rdata),
    .done_o(done), .undef_o(undef)
  );

  typedef struct packed {
    logic       bank; logic q;
    logic [4:0] vd; logic [4:0] vn; logic [4:0] vm;
    logic [3:0] imm; logic bad;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 5'd3,  5'd2,  5'd5,  4'd3,  1'b0},  // R2
    '{1'b1, 1'b0, 5'd0,  5'd7,  5'd9,  4'd0,  1'b0},  // R8
    '{1'b1, 1'b0, 5'd1,  5'd4,  5'd19, 4'd7,  1'b0},  // R2
    '{1'b1, 1'b0, 5'd1,  5'd4,  5'd5,  4'd8,  1'b1},  // R3
    '{1'b1, 1'b1, 5'd10, 5'd2,  5'd6,  4'd2,  1'b0},  // R5
    '{1'b1, 1'b1, 5'd12, 5'd20, 5'd30, 4'd11, 1'b0},  // R6
    '{1'b1, 1'b1, 5'd4,  5'd8,  5'd14, 4'd8,  1'b0},  // R8
    '{1'b1, 1'b1, 5'd5,  5'd8,  5'd14, 4'd1,  1'b1},  // R4
    '{1'b1, 1'b1, 5'd4,  5'd9,  5'd14, 4'd1,  1'b1},  // R4
    '{1'b1, 1'b1, 5'd4,  5'd8,  5'd15, 4'd1,  1'b1},  // R4
    '{1'b1, 1'b1, 5'd16, 5'd0,  5'd2,  4'd15, 1'b0},  // R6
    '{1'b1, 1'b1, 5'd2,  5'd2,  5'd4,  4'd5,  1'b0},  // R9
    '{1'b1, 1'b0, 5'd6,  5'd6,  5'd6,  4'd4,  1'b0},  // R9
    '{1'b0, 1'b0, 5'd3,  5'd17, 5'd5,  4'd1,  1'b1},  // R7
    '{1'b0, 1'b1, 5'd18, 5'd2,  5'd4,  4'd1,  1'b1},  // R7
    '{1'b0, 1'b1, 5'd6,  5'd2,  5'd8,  4'd0,  1'b0}   // R8
  };

  function automatic logic [63:0] pat(input int k);
    logic [63:0] v;
    for (int b = 0; b < 8; b++) v[b*8 +: 8] = 8'((k * 8 + b) & 255);
    return v;
  endfunction

  // byte window model: byte j of result is byte (sh+j) of {hi,lo}
  function automatic logic [63:0] win(input logic [63:0] lo, input logic [63:0] hi, input int sh);
    logic [7:0] bytes [16];
    logic [63:0] r;
    for (int b = 0; b < 8; b++) begin
      bytes[b] = lo[b*8 +: 8];
      bytes[b+8] = hi[b*8 +: 8];
    end
    for (int j = 0; j < 8; j++) r[j*8 +: 8] = bytes[sh + j];
    return r;
  endfunction

  function automatic logic [31:0] enc(input logic q, input logic [4:0] vd, input logic [4:0] vn,
                                      input logic [4:0] vm, input logic [3:0] imm);
    return {9'b1111_0010_1, vd[4], 2'b11, vn[3:0], vd[3:0], imm, vn[4], q, vm[4], 1'b0, vm[3:0]};
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [63:0] d);
    dbg_raddr = 5'(a);
    #1;
    d = dbg_rdata;
  endtask

  task automatic preload();
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      dbg_we = 1'b1; dbg_waddr = 5'(k); dbg_wdata = pat(k);
    end
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    insn = w; insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] d, e_lo, e_hi;
    logic [4:0] a1, a2;
    int sh;

    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11", "done after reset", 64'(done), 64'd0);
    check("R11", "undef after reset", 64'(undef), 64'd0);
    rd(0, d);  check("R11", "reg0 reset", d, 64'd0);
    rd(31, d); check("R11", "reg31 reset", d, 64'd0);
    rst_n = 1'b1;

    // R12: side port
    preload();
    rd(13, d); check("R12", "side write/read", d, pat(13));

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      preload();
      hi_bank_en = v.bank;
      issue(enc(v.q, v.vd, v.vn, v.vm, v.imm));
      check(v.bad ? "R10" : "R2", $sformatf("vec%0d done", i), 64'(done), 64'(!v.bad));
      check(v.bad ? "R3/R4/R7" : "R10", $sformatf("vec%0d undef", i), 64'(undef), 64'(v.bad));
      a1 = v.vd;
      a2 = {v.vd[4:1], 1'b1};
      sh = int'(v.imm[2:0]);
      if (!v.q) begin
        e_lo = win(pat(v.vn), pat(v.vm), sh);
        e_hi = pat(a2);
      end else if (!v.imm[3]) begin  // R5
        e_lo = win(pat(v.vn), pat(v.vn + 1), sh);
        e_hi = win(pat(v.vn + 1), pat(v.vm), sh);
      end else begin                 // R6
        e_lo = win(pat(v.vn + 1), pat(v.vm), sh);
        e_hi = win(pat(v.vm), pat(v.vm + 1), sh);
      end
      if (v.bad) begin
        e_lo = pat(a1);
        e_hi = pat(a2);
      end
      rd(a1, d); check(v.q ? "R5/R6" : "R2", $sformatf("vec%0d low dest", i), d, e_lo);
      if (a2 != a1) begin
        rd(a2, d); check(v.q ? "R5/R6" : "R10", $sformatf("vec%0d high dest", i), d, e_hi);
      end
    end
    hi_bank_en = 1'b1;

    // R8: explicit copy values
    preload();
    issue(enc(1'b0, 5'd1, 5'd11, 5'd3, 4'd0));
    rd(1, d); check("R8", "imm0 copies Rn", d, pat(11));
    issue(enc(1'b1, 5'd20, 5'd6, 5'd10, 4'd8));
    rd(20, d); check("R8", "imm8 low copies Rn+1", d, pat(7));
    rd(21, d); check("R8", "imm8 high copies Rm", d, pat(10));

    // R2: explicit little-endian literal
    preload();
    issue(enc(1'b0, 5'd3, 5'd2, 5'd5, 4'd3));
    rd(3, d); check("R2", "literal window", d, 64'h2A29281716151413);

    // R1: non-matching words, and one-cycle undef pulse (R10)
    preload();
    issue(enc(1'b0, 5'd3, 5'd2, 5'd5, 4'd1) | 32'h10);
    check("R1", "bit4 set undef", 64'(undef), 64'd1);
    check("R1", "bit4 set no done", 64'(done), 64'd0);
    @(negedge clk);
    check("R10", "undef single cycle", 64'(undef), 64'd0);
    rd(3, d); check("R1", "bit4 set no write", d, pat(3));
    issue(enc(1'b0, 5'd3, 5'd2, 5'd5, 4'd1) & ~32'h0080_0000);
    check("R1", "bit23 clear undef", 64'(undef), 64'd1);
    rd(3, d); check("R1", "bit23 clear no write", d, pat(3));
    issue(enc(1'b0, 5'd3, 5'd2, 5'd5, 4'd1) & ~32'h0010_0000);
    check("R1", "bit20 clear undef", 64'(undef), 64'd1);
    rd(3, d); check("R1", "bit20 clear no write", d, pat(3));

    // R10: done is a single pulse
    issue(enc(1'b0, 5'd3, 5'd2, 5'd5, 4'd1));
    check("R10", "done pulse", 64'(done), 64'd1);
    @(negedge clk);
    check("R10", "done single cycle", 64'(done), 64'd0);

    finish_run();
  end
endmodule